// File: doc/BRIEF.md
# Edge-Interrupt Port with Pulse Filter

This block is an eight-pin general-purpose I/O port whose pins can also raise an interrupt on a chosen edge, so that a keypad or similar switch matrix can wake the system. Each pin has its own direction bit and output data bit. Every input passes through a two-flop synchronizer. A per-pin counter then measures how long the synchronized level stays active, and short glitches are thrown away before they can be counted as edges.

For each pin, software picks a rising or a falling edge and can enable or mask the interrupt. When a filtered edge of the chosen polarity is seen, the pin's flag is set. The flag stays set until software writes a one to it. All pins share one interrupt request line. A pin contributes to that line only when both its flag and its enable are set. Edge capture works the same way whether the pin is an input or an output.

Registers are written through a single-cycle write strobe. They are read back through a combinational read port.

Top module: `edge_port`

## Requirements
- R1: After reset, `padOe`, `padOut`, every enable, every polarity bit and every flag are 0. `padOe[i]` equals direction bit i, where 1 means the pin drives, and `padOut` equals the data register.
- R2: Registers sit at these addresses on `wrAddr`/`rdAddr`: 0 data, 1 direction, 2 enable, 3 polarity, 4 flags. A write takes effect at the clock edge where `wrEn` is high. `rdData` shows the addressed register in the same cycle. Reading address 0 returns the data bit for output pins and the synchronized input level for input pins.
- R3: `irqReq` is high exactly when some pin has both its flag and its enable bit set.
- R4: A flag whose enable bit is 0 does not raise `irqReq`.
- R5: A polarity bit of 1 selects rising edges (active level high). A polarity bit of 0 selects falling edges (active level low).
- R6: An active-level pulse lasting 3 clocks or fewer never sets the flag.
- R7: An active-level pulse lasting 4 clocks or more, entered through an edge of the selected polarity, sets the pin's flag.
- R8: A set flag stays set until it is cleared by software. Edge capture also operates on pins configured as outputs.
- R9: Writing to address 4 clears each flag whose written bit is 1. A written 0 leaves that flag unchanged.
- R10: When a flag is being cleared in the same cycle that its pin completes a valid pulse, the flag ends up set.
- R11: Changing a pin's polarity bit restarts that pin's filter, so the polarity change alone never sets the flag.
- R12: For a pin change that is presented before clock edge 0, the flag becomes visible after clock edge 5. This is two synchronizer stages plus four filter samples, with the flag register updated on the last one.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rstN | input | 1 | Active-low synchronous reset |
| padIn | input | 8 | Pin levels from the pads |
| padOut | output | 8 | Data driven onto the pins |
| padOe | output | 8 | Per-pin output enable |
| wrEn | input | 1 | Register write strobe |
| wrAddr | input | 3 | Register write address |
| wrData | input | 8 | Register write data |
| rdAddr | input | 3 | Register read address |
| rdData | output | 8 | Register read data |
| irqReq | output | 1 | Shared interrupt request |

## Verification
The assertions assume that the pad inputs may change in any cycle but that the synchronizer output is the only pin view the filter sees. They also assume that every write lasts exactly one clock. The stimulus changes pins and write controls only at falling clock edges, and it holds each write strobe for a single cycle.

Each glitch test starts from a pin that has sat at the inactive level for several clocks. This ensures that the measured pulse is the only edge in flight when the flags are cleared and later read. The same-cycle clear test places its write on the exact edge where the flag register loads.

// File: rtl/edge_port_pkg.sv
package edge_port_pkg;
  localparam int ADDR_W = 3;
  localparam logic [ADDR_W-1:0] ADDR_DATA = 3'd0;
  localparam logic [ADDR_W-1:0] ADDR_DIR  = 3'd1;
  localparam logic [ADDR_W-1:0] ADDR_IEN  = 3'd2;
  localparam logic [ADDR_W-1:0] ADDR_POL  = 3'd3;
  localparam logic [ADDR_W-1:0] ADDR_FLAG = 3'd4;

  typedef struct packed {
    logic loadPol;   // polarity register is being written this cycle
    logic clrFlags;  // flag register is being written (write-one-to-clear)
  } portStrobe_t;
endpackage

// File: rtl/edge_port_filter.sv
module edge_port_filter #(
  parameter int FILT_LEN = 4
) (
  input  logic clk,
  input  logic rstN,
  input  logic syncIn,
  input  logic activeHigh,
  input  logic polChg,
  output logic setFlag
);
  localparam int CW = $clog2(FILT_LEN + 1);

  logic          prevIn;
  logic          armed;
  logic [CW-1:0] runCnt;
  logic          atActive;

  assign atActive = (syncIn == activeHigh);
  assign setFlag  = armed && atActive && (syncIn == prevIn) &&
                    (runCnt == CW'(FILT_LEN - 1));

  always_ff @(posedge clk) begin
    if (!rstN) begin
      prevIn <= 1'b0;
      armed  <= 1'b0;
      runCnt <= '0;
    end else begin
      prevIn <= syncIn;
      if (polChg) begin
        armed  <= 1'b0;
        runCnt <= '0;
      end else if (syncIn != prevIn) begin
        armed  <= atActive;
        runCnt <= atActive ? CW'(1) : '0;
      end else if (setFlag) begin
        armed <= 1'b0;
      end else if (armed && atActive) begin
        runCnt <= runCnt + CW'(1);
      end
    end
  end

  // Independent observer: consecutive active-level samples seen.
  logic [CW-1:0] obsRun;
  always_ff @(posedge clk) begin
    if (!rstN)                   obsRun <= '0;
    else if (!atActive)          obsRun <= '0;
    else if (syncIn != prevIn)   obsRun <= CW'(1);
    else if (obsRun < CW'(FILT_LEN)) obsRun <= obsRun + CW'(1);
  end

  p_short_pulse_r6: assert property (@(posedge clk) disable iff (!rstN)
    setFlag |-> (obsRun >= CW'(FILT_LEN - 1)));

  p_pol_quiet_r11: assert property (@(posedge clk) disable iff (!rstN)
    polChg |=> !setFlag);
endmodule

// File: rtl/edge_port_datapath.sv
module edge_port_datapath
  import edge_port_pkg::*;
#(
  parameter int PINS     = 8,
  parameter int FILT_LEN = 4
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic [PINS-1:0] padIn,
  input  logic [PINS-1:0] polReg,
  input  portStrobe_t     strb,
  input  logic [PINS-1:0] wrData,
  output logic [PINS-1:0] flags,
  output logic [PINS-1:0] syncPins
);
  logic [PINS-1:0] meta;
  logic [PINS-1:0] setMask;
  logic [PINS-1:0] clrMask;
  logic [PINS-1:0] polChg;

  assign clrMask = strb.clrFlags ? wrData : '0;
  assign polChg  = strb.loadPol ? (wrData ^ polReg) : '0;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      meta     <= '0;
      syncPins <= '0;
    end else begin
      meta     <= padIn;
      syncPins <= meta;
    end
  end

  for (genvar i = 0; i < PINS; i++) begin : g_pin
    edge_port_filter #(.FILT_LEN(FILT_LEN)) filt_i (
      .clk       (clk),
      .rstN      (rstN),
      .syncIn    (syncPins[i]),
      .activeHigh(polReg[i]),
      .polChg    (polChg[i]),
      .setFlag   (setMask[i])
    );
  end

  // A new event wins over a simultaneous clear.
  always_ff @(posedge clk) begin
    if (!rstN) flags <= '0;
    else       flags <= (flags & ~clrMask) | setMask;
  end

  p_w1c_r9: assert property (@(posedge clk) disable iff (!rstN)
    strb.clrFlags |=> ((flags & $past(wrData) & ~$past(setMask)) == '0));

  p_flag_hold_r8: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> (($past(flags) & ~$past(clrMask) & ~flags) == '0));

  p_set_wins_r10: assert property (@(posedge clk) disable iff (!rstN)
    (setMask != '0) |=> ((flags & $past(setMask)) == $past(setMask)));
endmodule

// File: rtl/edge_port_ctrl.sv
module edge_port_ctrl
  import edge_port_pkg::*;
#(
  parameter int PINS = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [PINS-1:0]   wrData,
  input  logic [ADDR_W-1:0] rdAddr,
  input  logic [PINS-1:0]   flags,
  input  logic [PINS-1:0]   syncPins,
  output logic [PINS-1:0]   rdData,
  output logic [PINS-1:0]   dirReg,
  output logic [PINS-1:0]   dataReg,
  output logic [PINS-1:0]   polReg,
  output portStrobe_t       strb,
  output logic              irqReq
);
  logic [PINS-1:0] ienReg;

  assign strb.loadPol  = wrEn && (wrAddr == ADDR_POL);
  assign strb.clrFlags = wrEn && (wrAddr == ADDR_FLAG);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      dirReg  <= '0;
      dataReg <= '0;
      ienReg  <= '0;
      polReg  <= '0;
    end else if (wrEn) begin
      case (wrAddr)
        ADDR_DATA: dataReg <= wrData;
        ADDR_DIR:  dirReg  <= wrData;
        ADDR_IEN:  ienReg  <= wrData;
        ADDR_POL:  polReg  <= wrData;
        default:   ;
      endcase
    end
  end

  always_comb begin
    case (rdAddr)
      ADDR_DATA: rdData = (dataReg & dirReg) | (syncPins & ~dirReg);
      ADDR_DIR:  rdData = dirReg;
      ADDR_IEN:  rdData = ienReg;
      ADDR_POL:  rdData = polReg;
      ADDR_FLAG: rdData = flags;
      default:   rdData = '0;
    endcase
  end

  assign irqReq = |(flags & ienReg);

  p_dir_load_r1: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && wrAddr == ADDR_DIR) |=> (dirReg == $past(wrData)));

  p_irq_masked_r4: assert property (@(posedge clk) disable iff (!rstN)
    (ienReg == '0) |-> !irqReq);

  p_irq_from_flag_r3: assert property (@(posedge clk) disable iff (!rstN)
    irqReq |-> (flags != '0));
endmodule

// File: rtl/edge_port.sv
module edge_port
  import edge_port_pkg::*;
#(
  parameter int PINS     = 8,
  parameter int FILT_LEN = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [PINS-1:0]   padIn,
  output logic [PINS-1:0]   padOut,
  output logic [PINS-1:0]   padOe,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [PINS-1:0]   wrData,
  input  logic [ADDR_W-1:0] rdAddr,
  output logic [PINS-1:0]   rdData,
  output logic              irqReq
);
  logic [PINS-1:0] flags;
  logic [PINS-1:0] syncPins;
  logic [PINS-1:0] dirReg;
  logic [PINS-1:0] dataReg;
  logic [PINS-1:0] polReg;
  portStrobe_t     strb;

  edge_port_ctrl #(.PINS(PINS)) ctrl_i (
    .clk     (clk),
    .rstN    (rstN),
    .wrEn    (wrEn),
    .wrAddr  (wrAddr),
    .wrData  (wrData),
    .rdAddr  (rdAddr),
    .flags   (flags),
    .syncPins(syncPins),
    .rdData  (rdData),
    .dirReg  (dirReg),
    .dataReg (dataReg),
    .polReg  (polReg),
    .strb    (strb),
    .irqReq  (irqReq)
  );

  edge_port_datapath #(.PINS(PINS), .FILT_LEN(FILT_LEN)) dp_i (
    .clk     (clk),
    .rstN    (rstN),
    .padIn   (padIn),
    .polReg  (polReg),
    .strb    (strb),
    .wrData  (wrData),
    .flags   (flags),
    .syncPins(syncPins)
  );

  assign padOut = dataReg;
  assign padOe  = dirReg;
endmodule

// File: tb/edge_port_tb_top.sv
`timescale 1ns/1ps
module edge_port_tb_top;
  import edge_port_pkg::*;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [7:0] padIn = '0;
  logic [7:0] padOut, padOe, rdData;
  logic       wrEn = 1'b0;
  logic [2:0] wrAddr = '0;
  logic [7:0] wrData = '0;
  logic [2:0] rdAddr = '0;
  logic       irqReq;

  int checks = 0;
  int errors = 0;
  logic [7:0] polShadow = '0;

  always #2.5 clk = ~clk;

  edge_port dut_i (
    .clk(clk), .rstN(rstN), .padIn(padIn), .padOut(padOut), .padOe(padOe),
    .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData), .rdAddr(rdAddr),
    .rdData(rdData), .irqReq(irqReq)
  );

  typedef struct packed {
    logic [2:0] pin;
    logic       rising;
    logic [7:0] width;
    logic       expSet;
  } vec_t;

  // R5/R6/R7 pulse-width table
  localparam vec_t VECS [8] = '{
    '{3'd0, 1'b1, 8'd1,  1'b0},
    '{3'd1, 1'b1, 8'd3,  1'b0},
    '{3'd2, 1'b1, 8'd4,  1'b1},
    '{3'd3, 1'b1, 8'd10, 1'b1},
    '{3'd4, 1'b0, 8'd2,  1'b0},
    '{3'd5, 1'b0, 8'd3,  1'b0},
    '{3'd6, 1'b0, 8'd4,  1'b1},
    '{3'd7, 1'b0, 8'd6,  1'b1}
  };

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic regWrite(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    wrEn = 1'b1; wrAddr = a; wrData = d;
    @(negedge clk);
    wrEn = 1'b0; wrData = '0;
  endtask

  task automatic regRead(input logic [2:0] a, output logic [7:0] d);
    @(negedge clk);
    rdAddr = a;
    #1 d = rdData;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  logic done = 1'b0;

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual hung expected done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [7:0] rv;
    idle(3);
    rstN = 1'b1;
    idle(1);

    // R1 reset state
    check("R1 oe", padOe, 8'h00);
    check("R1 out", padOut, 8'h00);
    check("R1 irq", {7'd0, irqReq}, 8'h00);
    regRead(ADDR_FLAG, rv); check("R1 flags", rv, 8'h00);

    // R1/R2 direction and data
    regWrite(ADDR_DIR, 8'hA5);
    regWrite(ADDR_DATA, 8'h3C);
    #1 check("R1 oe follows dir", padOe, 8'hA5);
    check("R1 out follows data", padOut, 8'h3C);
    regWrite(ADDR_IEN, 8'h00);
    regRead(ADDR_DIR, rv); check("R2 dir readback", rv, 8'hA5);
    padIn = 8'hFF; idle(4);
    regRead(ADDR_DATA, rv); check("R2 data mixed readback", rv, 8'h3C & 8'hA5 | 8'h5A);
    padIn = 8'h00;
    regWrite(ADDR_DIR, 8'h00);
    idle(8);
    regWrite(ADDR_FLAG, 8'hFF);

    // Table walk
    for (int k = 0; k < 8; k++) begin
      vec_t v;
      v = VECS[k];
      polShadow[v.pin] = v.rising;
      regWrite(ADDR_POL, polShadow);
      @(negedge clk); padIn[v.pin] = ~v.rising;
      idle(10);
      regWrite(ADDR_FLAG, 8'hFF);
      @(negedge clk); padIn[v.pin] = v.rising;
      repeat (int'(v.width)) @(negedge clk);
      padIn[v.pin] = ~v.rising;
      idle(8);
      regRead(ADDR_FLAG, rv);
      check(v.expSet ? "R7 valid pulse" : "R6 short pulse", rv,
            v.expSet ? (8'h01 << v.pin) : 8'h00);
    end
    padIn = 8'h00; polShadow = 8'hFF;
    regWrite(ADDR_POL, polShadow);
    idle(10);
    regWrite(ADDR_FLAG, 8'hFF);

    // R4 masked then R3 enabled
    @(negedge clk); padIn[2] = 1'b1; idle(8);
    #1 check("R4 masked irq", {7'd0, irqReq}, 8'h00);
    regWrite(ADDR_IEN, 8'h04);
    #1 check("R3 irq raised", {7'd0, irqReq}, 8'h01);
    // R9 writing zero has no effect, writing one clears
    regWrite(ADDR_FLAG, 8'h00);
    regRead(ADDR_FLAG, rv); check("R9 zero write", rv, 8'h04);
    regWrite(ADDR_FLAG, 8'h04);
    regRead(ADDR_FLAG, rv); check("R9 one clears", rv, 8'h00);
    #1 check("R3 irq dropped", {7'd0, irqReq}, 8'h00);
    padIn[2] = 1'b0;

    // R8 capture on an output pin, flag sticky
    regWrite(ADDR_DIR, 8'h20);
    @(negedge clk); padIn[5] = 1'b1; idle(6);
    padIn[5] = 1'b0; idle(12);
    regRead(ADDR_FLAG, rv); check("R8 output pin sticky flag", rv, 8'h20);
    regWrite(ADDR_DIR, 8'h00);
    regWrite(ADDR_FLAG, 8'hFF);
    idle(4);

    // R12 latency: change before edge 0, flag after edge 5
    @(negedge clk); padIn[1] = 1'b1;
    idle(5);
    rdAddr = ADDR_FLAG;
    #1 check("R12 not yet at edge 4", rdData, 8'h00);
    @(negedge clk);
    #1 check("R12 visible after edge 5", rdData, 8'h02);
    padIn[1] = 1'b0;
    idle(6);
    regWrite(ADDR_FLAG, 8'hFF);
    idle(4);

    // R10 clear coincides with flag load at edge 5
    @(negedge clk); padIn[3] = 1'b1;
    idle(4);
    @(negedge clk); wrEn = 1'b1; wrAddr = ADDR_FLAG; wrData = 8'h08;
    @(negedge clk); wrEn = 1'b0; wrData = '0;
    regRead(ADDR_FLAG, rv); check("R10 set wins", rv, 8'h08);
    padIn[3] = 1'b0;
    idle(6);
    regWrite(ADDR_FLAG, 8'hFF);

    // R11 polarity change alone never sets a flag
    regWrite(ADDR_POL, 8'h00);
    idle(10);
    regRead(ADDR_FLAG, rv); check("R11 to falling while low", rv, 8'h00);
    @(negedge clk); padIn = 8'hFF; idle(10);
    regWrite(ADDR_FLAG, 8'hFF);
    regWrite(ADDR_POL, 8'hFF);
    idle(10);
    regRead(ADDR_FLAG, rv); check("R11 to rising while high", rv, 8'h00);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule